// File: doc/BRIEF.md
# ADC acquisition and conversion sequencer

This block is the digital front end of a 12-bit sampling converter that sits on an 8-bit parallel bus. A host writes a control byte with chip select held low. The block latches the byte on the rising edge of the write strobe. The byte selects an input channel, a unipolar or bipolar range, a power-down setting and one of two acquisition styles. The block then drives the track signal to the sample-and-hold. It marks the sample point with a one-cycle pulse and times a fixed-length conversion. A behavioural source supplies the 12-bit result code, which the block latches when the conversion completes.

In the timed style, acquisition lasts a fixed number of clocks and the conversion follows by itself. In the open style, acquisition runs until the host writes again. A second write in the open style either closes the window and starts the conversion, or reopens the window. Any write made during a conversion abandons that conversion and begins a new acquisition. When a result is ready, the block pulls an active-low interrupt. The host reads the result in two bus reads chosen by a byte-select input. The upper read returns the top four result bits and fills its upper nibble with sign copies or zeros, according to the range.

Top module: `adc_seq`

## Requirements
- R1: A write event is a clock cycle in which `csN` is low, `wrN` is high and `wrN` was low on the previous clock. On a write event the control byte on `busIn` is latched with this layout: bits 3..0 are the channel, bit 4 is bipolar (1) or unipolar (0), bit 5 is the acquisition style (1 = open, 0 = timed), and bits 7..6 are the power-down code. The latched fields appear on `chanSel`, `bipolarSel` and `pwrDown` from the following cycle.
- R2: After a timed-style write, `trackEn` is high for exactly 6 clock cycles. `samplePulse` is then high for one cycle, which is the first conversion cycle, and no further write is needed.
- R3: A conversion lasts 12 cycles (`convBusy` high). `intN` falls 12 cycles after the conversion starts, which is 18 cycles after a timed-style write event.
- R4: A write event during a conversion abandons it. No interrupt is raised for the abandoned conversion, and a new acquisition starts from the new byte.
- R5: After an open-style write, `trackEn` stays high and no conversion starts for as long as no further write occurs.
- R6: During an open acquisition, a write with bit 5 = 0 starts the conversion at once. `intN` falls 12 cycles after that write event.
- R7: During an open acquisition, a write with bit 5 = 1 restarts the open acquisition without converting.
- R8: A write that ends or restarts an open acquisition may change the power-down code. If its channel differs from the latched channel, `chanErr` rises and stays high until reset.
- R9: While `busOe` is high and `hiByteSel` is low, `busOut` carries result bits 7..0.
- R10: While `busOe` is high and `hiByteSel` is high, `busOut[3:0]` carries result bits 11..8. `busOut[7:4]` is 4'hF when the conversion was bipolar and result bit 11 is 1, and 0 otherwise.
- R11: `intN` is cleared by a read event (`csN` low and `rdN` falling) or by a write event. If a completion and a read event fall in the same cycle, `intN` asserts. If a write event falls in the last conversion cycle, the conversion is abandoned.
- R12: `busOe` is high only while both `csN` and `rdN` are low. While `busOe` is low, `busOut` is 0.
- R13: After reset, `intN` is 1, `trackEn`, `convBusy`, `samplePulse` and `chanErr` are 0, and the control fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| hiByteSel | input | 1 | Selects the upper result byte on a read |
| busIn | input | 8 | Control byte written by the host |
| resultCode | input | 12 | Code from the behavioural converter |
| busOut | output | 8 | Read data |
| busOe | output | 1 | Read data enable (bus not high-impedance) |
| intN | output | 1 | Active-low end-of-conversion interrupt |
| chanSel | output | 4 | Latched channel |
| bipolarSel | output | 1 | Latched range |
| pwrDown | output | 2 | Latched power-down code |
| trackEn | output | 1 | Sample-and-hold tracking |
| convBusy | output | 1 | Conversion in progress |
| samplePulse | output | 1 | Sample point, first conversion cycle |
| chanErr | output | 1 | Sticky channel mismatch flag |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a completed conversion and a new write. The second is a completed conversion and a read that would clear the interrupt. The bench counts clock cycles from a timed write and lands a second write exactly in the twelfth conversion cycle. It expects no interrupt and a fresh 18-cycle sequence. In another run, it drops the read strobe so that the read event falls in that same cycle, and it expects `intN` to be low afterwards, because completion takes priority over the read clear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // control byte field positions
  localparam int FLD_CHAN_LO = 0;
  localparam int FLD_CHAN_W  = 4;
  localparam int FLD_BIP     = 4;
  localparam int FLD_MODE    = 5;
  localparam int FLD_PD_LO   = 6;
  localparam int FLD_PD_W    = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ACQ_TIMED,
    SEQ_ACQ_OPEN,
    SEQ_CONV
  } seqState_t;

  typedef struct packed {
    logic loadCtrl;   // write event: capture control fields
    logic checkChan;  // write closing/restarting an open window
    logic convDone;   // last conversion cycle, not abandoned
    logic readClr;    // read event
  } seqStrobes_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ACQ_CYCLES  = 6,
  parameter int CONV_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        wrN,
  input  logic        rdN,
  input  logic        openMode,
  output seqStrobes_t strobes,
  output logic        trackEn,
  output logic        convBusy,
  output logic        samplePulse
);

  localparam int MAX_CYC = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             wrNq, rdNq;
  logic             writeEvt, readEvt;

  assign writeEvt = !wrNq && wrN && !csN;
  assign readEvt  = rdNq && !rdN && !csN;

  always_comb begin
    strobes           = '0;
    strobes.loadCtrl  = writeEvt;
    strobes.checkChan = writeEvt && (state == SEQ_ACQ_OPEN);
    strobes.convDone  = !writeEvt && (state == SEQ_CONV) && (cnt == CONV_LAST);
    strobes.readClr   = readEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrNq <= 1'b1;
      rdNq <= 1'b1;
    end else begin
      wrNq <= wrN;
      rdNq <= rdN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else if (writeEvt) begin
      cnt <= '0;
      if (openMode)                   state <= SEQ_ACQ_OPEN;
      else if (state == SEQ_ACQ_OPEN) state <= SEQ_CONV;
      else                            state <= SEQ_ACQ_TIMED;
    end else begin
      unique case (state)
        SEQ_ACQ_TIMED: begin
          if (cnt == ACQ_LAST) begin
            state <= SEQ_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_CONV: begin
          if (cnt == CONV_LAST) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign trackEn     = (state == SEQ_ACQ_TIMED) || (state == SEQ_ACQ_OPEN);
  assign convBusy    = (state == SEQ_CONV);
  assign samplePulse = (state == SEQ_CONV) && (cnt == '0);

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BUS_W  = 8,
  parameter int CHAN_W = 4,
  parameter int PD_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [CHAN_W-1:0] chanIn,
  input  logic              bipIn,
  input  logic [PD_W-1:0]   pdIn,
  input  logic [RES_W-1:0]  resultCode,
  input  logic              csN,
  input  logic              rdN,
  input  logic              hiByteSel,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  output logic              intN,
  output logic [CHAN_W-1:0] chanSel,
  output logic              bipolarSel,
  output logic [PD_W-1:0]   pwrDown,
  output logic              chanErr
);

  localparam int HI_W  = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  logic [RES_W-1:0] resReg;
  logic             resBip;
  logic             intFlag;
  logic [BUS_W-1:0] hiWord, loWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanSel    <= '0;
      bipolarSel <= 1'b0;
      pwrDown    <= '0;
      chanErr    <= 1'b0;
    end else if (strobes.loadCtrl) begin
      chanSel    <= chanIn;
      bipolarSel <= bipIn;
      pwrDown    <= pdIn;
      if (strobes.checkChan && (chanIn != chanSel)) chanErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg <= '0;
      resBip <= 1'b0;
    end else if (strobes.convDone) begin
      resReg <= resultCode;
      resBip <= bipolarSel;
    end
  end

  // completion outranks a same-cycle read; a write never meets convDone
  always_ff @(posedge clk) begin
    if (!rstN)                  intFlag <= 1'b0;
    else if (strobes.loadCtrl)  intFlag <= 1'b0;
    else if (strobes.convDone)  intFlag <= 1'b1;
    else if (strobes.readClr)   intFlag <= 1'b0;
  end

  assign intN   = !intFlag;
  assign loWord = resReg[BUS_W-1:0];
  assign hiWord = {{PAD_W{resBip & resReg[RES_W-1]}}, resReg[RES_W-1:BUS_W]};
  assign busOe  = !csN && !rdN;
  assign busOut = busOe ? (hiByteSel ? hiWord : loWord) : '0;

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int ACQ_CYCLES  = 6,
  parameter int CONV_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        wrN,
  input  logic        rdN,
  input  logic        hiByteSel,
  input  logic [7:0]  busIn,
  input  logic [11:0] resultCode,
  output logic [7:0]  busOut,
  output logic        busOe,
  output logic        intN,
  output logic [3:0]  chanSel,
  output logic        bipolarSel,
  output logic [1:0]  pwrDown,
  output logic        trackEn,
  output logic        convBusy,
  output logic        samplePulse,
  output logic        chanErr
);

  seqStrobes_t strobes;

  adc_seq_ctrl #(
    .ACQ_CYCLES (ACQ_CYCLES),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .wrN        (wrN),
    .rdN        (rdN),
    .openMode   (busIn[FLD_MODE]),
    .strobes    (strobes),
    .trackEn    (trackEn),
    .convBusy   (convBusy),
    .samplePulse(samplePulse)
  );

  adc_seq_dp #(
    .RES_W (12),
    .BUS_W (8),
    .CHAN_W(FLD_CHAN_W),
    .PD_W  (FLD_PD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .chanIn    (busIn[FLD_CHAN_LO +: FLD_CHAN_W]),
    .bipIn     (busIn[FLD_BIP]),
    .pdIn      (busIn[FLD_PD_LO +: FLD_PD_W]),
    .resultCode(resultCode),
    .csN       (csN),
    .rdN       (rdN),
    .hiByteSel (hiByteSel),
    .busOut    (busOut),
    .busOe     (busOe),
    .intN      (intN),
    .chanSel   (chanSel),
    .bipolarSel(bipolarSel),
    .pwrDown   (pwrDown),
    .chanErr   (chanErr)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CONV_CYCLES = 12
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       hiByteSel,
  input logic [7:0] busOut,
  input logic       busOe,
  input logic       intN,
  input logic       trackEn,
  input logic       convBusy,
  input logic       samplePulse,
  input logic       chanErr
);

  logic [15:0] convRun;

  always_ff @(posedge clk) begin
    if (!rstN)         convRun <= '0;
    else if (convBusy) convRun <= convRun + 1'b1;
    else               convRun <= '0;
  end

  AST_CONV_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    convRun <= 16'(CONV_CYCLES)); // R3

  AST_INT_AFTER_CONV: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(convBusy)); // R11

  AST_SAMPLE_AFTER_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> ($past(trackEn) || $past(convBusy))); // R2

  AST_TRACK_CONV_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(trackEn && convBusy)); // R5

  AST_CHAN_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    chanErr |=> chanErr); // R8

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busOut == 8'h00)); // R12

  AST_BUS_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !csN); // R12

  AST_HI_NIBBLE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && hiByteSel) |-> (busOut[7:4] == 4'h0 || busOut[7:4] == 4'hF)); // R10

endmodule

bind adc_seq adc_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .hiByteSel  (hiByteSel),
  .busOut     (busOut),
  .busOe      (busOe),
  .intN       (intN),
  .trackEn    (trackEn),
  .convBusy   (convBusy),
  .samplePulse(samplePulse),
  .chanErr    (chanErr)
);

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;

  logic        clk = 1'b0;
  logic        rstN, csN, wrN, rdN, hiByteSel;
  logic [7:0]  busIn;
  logic [11:0] resultCode;
  logic [7:0]  busOut;
  logic        busOe, intN, bipolarSel, trackEn, convBusy, samplePulse, chanErr;
  logic [3:0]  chanSel;
  logic [1:0]  pwrDown;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_seq u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .hiByteSel(hiByteSel), .busIn(busIn), .resultCode(resultCode),
    .busOut(busOut), .busOe(busOe), .intN(intN), .chanSel(chanSel),
    .bipolarSel(bipolarSel), .pwrDown(pwrDown), .trackEn(trackEn),
    .convBusy(convBusy), .samplePulse(samplePulse), .chanErr(chanErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write event edge is 1.5 cycles later; returns half a cycle after it
  task automatic doWrite(input logic [7:0] b);
    csN = 1'b0; wrN = 1'b0; busIn = b;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
  endtask

  // counts negedges until intN is low; records the position of the sample pulse
  task automatic waitInt(output int n, output int samplePos);
    n = 0; samplePos = -1;
    while (intN && n < 200) begin
      @(negedge clk); n++;
      if (samplePulse && samplePos < 0) samplePos = n;
    end
  endtask

  task automatic readByte(input logic hi, output logic [7:0] d, output logic oe);
    csN = 1'b0; rdN = 1'b0; hiByteSel = hi;
    #1; d = busOut; oe = busOe;
    @(negedge clk); rdN = 1'b1; csN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, sp;
    logic [7:0] d;
    logic oe;
    rstN = 1'b0; csN = 1'b1; wrN = 1'b1; rdN = 1'b1; hiByteSel = 1'b0;
    busIn = 8'h00; resultCode = 12'h000;
    repeat (3) @(negedge clk);
    check(intN == 1'b1 && trackEn == 1'b0 && convBusy == 1'b0, "R13 reset outputs",
          {intN, trackEn, convBusy}, 3'b100);
    check(chanErr == 1'b0 && chanSel == 4'h0 && pwrDown == 2'h0 && !samplePulse,
          "R13 reset fields", {chanErr, chanSel, pwrDown}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // timed-style sweep over range, channel, power-down and result codes
    for (int bip = 0; bip < 2; bip++) begin
      for (int i = 0; i < 16; i++) begin
        logic [11:0] code;
        logic [7:0]  hiExp;
        logic [1:0]  pd;
        code = 12'((i * 273) ^ (bip * 12'h5A5));
        pd   = 2'(i % 4);
        resultCode = code;
        doWrite({pd, 1'b0, 1'(bip), 4'(i)});
        check(chanSel == 4'(i) && bipolarSel == 1'(bip) && pwrDown == pd, "R1 fields",
              {chanSel, bipolarSel, pwrDown}, {4'(i), 1'(bip), pd});
        check(trackEn == 1'b1 && convBusy == 1'b0, "R2 tracking after write",
              {trackEn, convBusy}, 2'b10);
        waitInt(n, sp);
        check(sp == 6, "R2 sample point", sp, 6);
        check(n == 18, "R3 interrupt latency", n, 18);
        readByte(1'b0, d, oe);
        check(oe == 1'b1 && d == code[7:0], "R9 low byte", d, code[7:0]);
        check(intN == 1'b1, "R11 read clears interrupt", intN, 1);
        hiExp = {4'h0, code[11:8]} | ((bip == 1 && code[11]) ? 8'hF0 : 8'h00);
        readByte(1'b1, d, oe);
        check(oe == 1'b1 && d == hiExp, "R10 high byte", d, hiExp);
      end
    end

    // bus enable qualification
    csN = 1'b1; rdN = 1'b0; #1;
    check(busOe == 1'b0 && busOut == 8'h00, "R12 read without select", {busOe, busOut}, 0);
    csN = 1'b0; rdN = 1'b1; #1;
    check(busOe == 1'b0 && busOut == 8'h00, "R12 select without read", {busOe, busOut}, 0);
    csN = 1'b1;
    @(negedge clk);

    // abort mid-conversion
    resultCode = 12'h3C7;
    doWrite(8'h05);
    repeat (10) @(negedge clk);
    check(convBusy == 1'b1, "R4 in conversion before abort", convBusy, 1);
    doWrite(8'h06);
    check(trackEn == 1'b1 && convBusy == 1'b0 && chanSel == 4'h6, "R4 new acquisition",
          {trackEn, convBusy, chanSel}, {2'b10, 4'h6});
    waitInt(n, sp);
    check(n == 18, "R4 full restart latency", n, 18);
    readByte(1'b0, d, oe);

    // write landing in the last conversion cycle
    doWrite(8'h05);
    repeat (16) @(negedge clk);
    doWrite(8'h07);
    check(intN == 1'b1 && trackEn == 1'b1, "R11 write in last cycle aborts",
          {intN, trackEn}, 2'b11);
    waitInt(n, sp);
    check(n == 18, "R11 restart after late write", n, 18);
    readByte(1'b0, d, oe);

    // read landing in the completion cycle
    doWrite(8'h05);
    repeat (17) @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    check(intN == 1'b0, "R11 completion beats same-cycle read", intN, 0);
    rdN = 1'b1; csN = 1'b1;
    @(negedge clk);
    readByte(1'b0, d, oe);
    check(intN == 1'b1, "R11 later read clears", intN, 1);

    // open acquisition window
    resultCode = 12'hABC;
    doWrite(8'h75);
    repeat (40) @(negedge clk);
    check(trackEn == 1'b1 && convBusy == 1'b0 && intN == 1'b1, "R5 window stays open",
          {trackEn, convBusy, intN}, 3'b101);
    doWrite(8'h75);
    repeat (20) @(negedge clk);
    check(trackEn == 1'b1 && convBusy == 1'b0 && chanErr == 1'b0, "R7 window restarted",
          {trackEn, convBusy, chanErr}, 3'b100);
    doWrite(8'h95);
    check(pwrDown == 2'h2 && chanErr == 1'b0, "R8 power-down updated, no error",
          {pwrDown, chanErr}, 3'b100);
    check(convBusy == 1'b1 && samplePulse == 1'b1, "R6 conversion starts at once",
          {convBusy, samplePulse}, 2'b11);
    waitInt(n, sp);
    check(n == 12, "R6 interrupt latency", n, 12);
    readByte(1'b1, d, oe);
    check(d == 8'hFA, "R10 bipolar sign fill", d, 8'hFA);

    // channel mismatch on the closing write
    doWrite(8'h75);
    doWrite(8'h92);
    check(chanErr == 1'b1, "R8 mismatch flagged", chanErr, 1);
    doWrite(8'h05);
    waitInt(n, sp);
    check(chanErr == 1'b1, "R8 flag sticky", chanErr, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule